// File: doc/BRIEF.md
# I2C Bus Start/Stop Monitor

This block watches the clock and data lines of a two-wire bus without driving them. It detects the two framing conditions that only a master can produce. A Start is the data line falling while the clock line is high. A Stop is the data line rising while the clock line is high. It keeps a sticky flag for the condition seen last. A master that shares the bus with others reads the derived bus-free indication before it tries to take control of the bus.

The line inputs must already be synchronised to `clk`. The block registers them again for a configurable number of stages, then compares each sample with the one before it. A condition detected in one cycle is registered in the next cycle, and the status outputs follow one cycle after that. With the default single input stage, a line change driven just after a clock edge appears on the outputs after the third rising edge. A one-cycle interrupt marks a Stop that closes a busy bus. This includes a Stop seen by a master that lost arbitration and kept watching the lines.

Top module: `i2c_bus_monitor`

## Requirements
- R1: With SCL high in two consecutive samples and SDA going 1 then 0, a Start is detected. The block then sets `start_seen` and clears `stop_seen`. With the default single input stage, both outputs take their new values after the third rising clock edge that follows the line change.
- R2: With SCL high in two consecutive samples and SDA going 0 then 1, a Stop is detected. The block then sets `stop_seen` and clears `start_seen`, with the same latency as R1.
- R3: A change of SDA while SCL is low is not a condition. A change of SDA in the same sample in which SCL rises is also not a condition. In both cases the status outputs do not change.
- R4: `bus_free` is 1 when `stop_seen` is 1, or when `start_seen` and `stop_seen` are both 0. Otherwise it is 0. It changes in the same cycle as the flags.
- R5: While `rst` is 1, `start_seen`, `stop_seen` and `stop_irq` are 0 and `bus_free` is 1. The line history resets to the idle level, which is both lines high. Releasing reset while SCL is low therefore produces no condition.
- R6: While `en` is 0, both status flags are cleared on the next clock edge and stay 0. Conditions on the lines do not set them and raise no interrupt.
- R7: A Stop detected while `start_seen` is 1 (the bus is busy), with `en` and `irq_en` both 1, drives `stop_irq` high for exactly one cycle. That cycle is the same cycle in which `stop_seen` rises.
- R8: A Stop detected while `start_seen` is 0 raises no interrupt. A Stop detected while `irq_en` is 0 also raises no interrupt.
- R9: A repeated Start, meaning a Start while `start_seen` is already 1, leaves `start_seen` at 1 and `stop_seen` at 0.
- R10: `start_seen` and `stop_seen` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Monitor enable; when low, the status flags are cleared |
| irq_en | input | 1 | Enable for the Stop interrupt |
| scl_in | input | 1 | Synchronised clock line level |
| sda_in | input | 1 | Synchronised data line level |
| start_seen | output | 1 | Sticky flag: the last condition seen was a Start |
| stop_seen | output | 1 | Sticky flag: the last condition seen was a Stop |
| bus_free | output | 1 | The bus may be claimed by a new master |
| stop_irq | output | 1 | One-cycle pulse on a Stop that ends a busy bus |

## Verification
The assertions check the following on every cycle:
- each detected condition moves the flags on the next edge;
- a disabled block has both flags clear;
- the two flags are never set together;
- the interrupt is a lone pulse that coincides with a set stop flag and was enabled;
- `bus_free` agrees with the flags.

Whether a detected condition really corresponds to the line levels can only be shown by the bench's line sequences. This covers clock-low data changes, simultaneous edges, repeated Starts, Stops on an idle bus and reset released while the clock is low.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  // One-cycle indications of a bus framing condition
  typedef struct packed {
    logic start;
    logic stop;
  } bus_cond_t;
endpackage

// File: rtl/i2c_line_edge.sv
module i2c_line_edge
  import i2c_mon_pkg::*;
#(
  parameter int IN_STAGES = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      scl_i,
  input  logic      sda_i,
  output bus_cond_t cond_o
);
  localparam int LAST = IN_STAGES - 1;

  logic [IN_STAGES-1:0] scl_sh;
  logic [IN_STAGES-1:0] sda_sh;
  logic                 scl_prev;
  logic                 sda_prev;
  bus_cond_t            cond_c;

  // Input register chain; idle level is high on both lines
  generate
    for (genvar k = 0; k < IN_STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_sh[0] <= 1'b1;
            sda_sh[0] <= 1'b1;
          end else begin
            scl_sh[0] <= scl_i;
            sda_sh[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_sh[k] <= 1'b1;
            sda_sh[k] <= 1'b1;
          end else begin
            scl_sh[k] <= scl_sh[k-1];
            sda_sh[k] <= sda_sh[k-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_sh[LAST];
      sda_prev <= sda_sh[LAST];
    end
  end

  // A condition requires SCL high in both samples
  always_comb begin
    cond_c.start = scl_prev & scl_sh[LAST] &  sda_prev & ~sda_sh[LAST];
    cond_c.stop  = scl_prev & scl_sh[LAST] & ~sda_prev &  sda_sh[LAST];
  end

  always_ff @(posedge clk) begin
    if (rst) cond_o <= '0;
    else     cond_o <= cond_c;
  end
endmodule

// File: rtl/i2c_bus_status.sv
module i2c_bus_status
  import i2c_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      irq_en,
  input  bus_cond_t cond_i,
  output logic      s_o,
  output logic      p_o,
  output logic      free_o,
  output logic      irq_o
);
  logic s_nx, p_nx;

  always_comb begin
    s_nx = s_o;
    p_nx = p_o;
    if (!en) begin
      s_nx = 1'b0;
      p_nx = 1'b0;
    end else if (cond_i.start) begin
      s_nx = 1'b1;
      p_nx = 1'b0;
    end else if (cond_i.stop) begin
      s_nx = 1'b0;
      p_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_o    <= 1'b0;
      p_o    <= 1'b0;
      free_o <= 1'b1;
      irq_o  <= 1'b0;
    end else begin
      s_o    <= s_nx;
      p_o    <= p_nx;
      free_o <= p_nx | (~s_nx & ~p_nx);
      // Busy means the last condition was a Start
      irq_o  <= en & irq_en & cond_i.stop & s_o;
    end
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int IN_STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic irq_en,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free,
  output logic stop_irq
);
  bus_cond_t cond;

  i2c_line_edge #(.IN_STAGES(IN_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_in),
    .sda_i  (sda_in),
    .cond_o (cond)
  );

  i2c_bus_status u_stat (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .irq_en (irq_en),
    .cond_i (cond),
    .s_o    (start_seen),
    .p_o    (stop_seen),
    .free_o (bus_free),
    .irq_o  (stop_irq)
  );
endmodule

// File: rtl/i2c_mon_chk.sv
module i2c_mon_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic irq_en,
  input logic cond_start,
  input logic cond_stop,
  input logic s,
  input logic p,
  input logic free,
  input logic irq
);
  p_start_sets_s_r1: assert property (@(posedge clk) disable iff (rst)
    en && cond_start |=> s && !p);
  p_stop_sets_p_r2: assert property (@(posedge clk) disable iff (rst)
    en && cond_stop |=> p && !s);
  p_free_match_r4: assert property (@(posedge clk) disable iff (rst)
    free == (p || (!s && !p)));
  p_disable_clears_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !s && !p);
  p_busy_stop_irq_r7: assert property (@(posedge clk) disable iff (rst)
    en && irq_en && cond_stop && s |=> irq);
  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  p_irq_with_stop_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> p && !s);
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en) && $past(s));
  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(s && p));
endmodule

bind i2c_bus_monitor i2c_mon_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .irq_en     (irq_en),
  .cond_start (cond.start),
  .cond_stop  (cond.stop),
  .s          (start_seen),
  .p          (stop_seen),
  .free       (bus_free),
  .irq        (stop_irq)
);

// File: tb/sim_i2c_bus_monitor.sv
module sim_i2c_bus_monitor;
  logic clk = 1'b0;
  logic rst, en, irq_en, scl_in, sda_in;
  logic start_seen, stop_seen, bus_free, stop_irq;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  i2c_bus_monitor u0 (
    .clk(clk), .rst(rst), .en(en), .irq_en(irq_en),
    .scl_in(scl_in), .sda_in(sda_in),
    .start_seen(start_seen), .stop_seen(stop_seen),
    .bus_free(bus_free), .stop_irq(stop_irq)
  );

  // {scl, sda, irq_en, en, exp_s, exp_p, exp_free, exp_irq}
  localparam logic [7:0] VEC [18] = '{
    8'b1111_0010, // idle, flags clear, free           R4
    8'b1011_1000, // start                            R1
    8'b0011_1000, // clock low                        R3
    8'b0111_1000, // data rises while clock low       R3
    8'b1111_1000, // clock high again                 R3
    8'b1011_1000, // repeated start                   R9
    8'b0011_1000,
    8'b1011_1000,
    8'b1111_0111, // stop on busy bus, irq pulse      R2 R7
    8'b1111_0110, // hold, pulse gone                 R7
    8'b0111_0110,
    8'b0011_0110, // data falls while clock low       R3
    8'b1011_0110,
    8'b1111_0110, // stop on idle bus, no irq         R8
    8'b1001_1000, // start with irq disabled          R1
    8'b1101_0110, // stop with irq disabled           R8
    8'b0111_0110,
    8'b1011_0110  // clock rises as data falls        R3
  };

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic es, input logic ep,
                           input logic ef, input logic ei);
    check(req, "start_seen", start_seen, es);
    check(req, "stop_seen",  stop_seen,  ep);
    check(req, "bus_free",   bus_free,   ef);
    check(req, "stop_irq",   stop_irq,   ei);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; en = 1'b1; irq_en = 1'b1; scl_in = 1'b1; sda_in = 1'b1;
    wait_neg(3);
    check_all("R5 reset", 1'b0, 1'b0, 1'b1, 1'b0);
    rst = 1'b0;
    wait_neg(3);

    // Table walk: latency of three edges per line change
    for (int i = 0; i < 18; i++) begin
      scl_in = VEC[i][7]; sda_in = VEC[i][6];
      irq_en = VEC[i][5]; en = VEC[i][4];
      wait_neg(3);
      check_all($sformatf("R1/R2/R3/R4/R7/R8/R9 row %0d", i),
                VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // Back to idle, then start, go busy with clock low
    scl_in = 1'b1; sda_in = 1'b1; irq_en = 1'b1; wait_neg(3);
    sda_in = 1'b0; wait_neg(3);
    check("R1", "start_seen", start_seen, 1'b1);
    scl_in = 1'b0; wait_neg(3);

    // R6: disabling clears the flags on the next edge
    en = 1'b0; wait_neg(1);
    check_all("R6 disable", 1'b0, 1'b0, 1'b1, 1'b0);
    // Stop, start, stop while disabled: nothing moves
    scl_in = 1'b1; wait_neg(2);
    sda_in = 1'b1; wait_neg(4);
    check_all("R6 stop while off", 1'b0, 1'b0, 1'b1, 1'b0);
    sda_in = 1'b0; wait_neg(4);
    check_all("R6 start while off", 1'b0, 1'b0, 1'b1, 1'b0);
    sda_in = 1'b1; wait_neg(2);
    check("R6", "stop_irq", stop_irq, 1'b0);
    wait_neg(2);
    en = 1'b1; wait_neg(2);

    // R5: reset during a busy bus, released with clock low
    sda_in = 1'b0; wait_neg(3);
    check("R1", "start_seen", start_seen, 1'b1);
    scl_in = 1'b0; wait_neg(2);
    rst = 1'b1; wait_neg(1);
    check_all("R5 reset busy", 1'b0, 1'b0, 1'b1, 1'b0);
    rst = 1'b0; wait_neg(4);
    check_all("R5 release clock low", 1'b0, 1'b0, 1'b1, 1'b0);

    // R8: a Stop with no Start since reset gives no pulse
    scl_in = 1'b1; wait_neg(2);
    sda_in = 1'b1; wait_neg(3);
    check_all("R8 stop after reset", 1'b0, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule